// File: doc/BRIEF.md
# Power Switch Wake-Up Sequencer

This block sits in the always-on domain and drives the enable lines of a bank of power-gating switch groups that feed one switchable domain. When a wake request arrives, it turns the groups on under one of three policies. The first closes every group in a single cycle for the lowest latency. The second is a self-timed chain in which each enable restarts a delay timer, and the expiry of that timer closes the next group. The third steps forward one group at a time, and each step waits for a rail-good comparator on the virtual supply. An adaptive setting picks the fast policy for urgent requests and the timed chain for all others.

After the last group is closed, and in feedback mode after the rail is confirmed good, a power-good output tells the system that the domain can be used. A sleep request opens every switch at once. In feedback mode a watchdog limits how long each step may wait for the rail. If the rail does not come up in time, the sequence halts with an error flag. All state is held in always-on registers, so the block keeps its state while the gated domain is off.

Top module: `pwr_switch_seq`

## Requirements
- R1: During and immediately after a synchronous active-low reset, every group enable, power-good and the rail error flag are 0.
- R2: Bit k of `sw_en` drives group k (1 = switches conducting, 0 = open). During a wake sequence the groups close in ascending index order, and no group that is already closed opens again until a sleep request.
- R3: Mode 0 (fast): all `NUM_GROUPS` enables go to 1 on the second rising edge after the edge that samples `wake_req`, and power-good follows one edge later.
- R4: Mode 1 (timed chain): group 0 closes on the second edge after the edge that samples the wake request, and each further group closes D edges after the previous one. D is `step_delay`, and a value of 0 acts as 1.
- R5: Mode 2 (rail feedback): after a group closes, the next group closes only on the second edge after `rail_ok` is sampled high. Counting the sampling edge as the first, power-good rises on the second edge after `rail_ok` is sampled high for the last group.
- R6: Power-good is 1 only while every enable is 1, and it rises exactly one cycle after the last enable rises.
- R7: Mode 3 (adaptive) behaves as mode 0 when `wake_urgent` is 1 at the sampled wake request, and otherwise behaves as mode 1.
- R8: A sampled `sleep_req` clears every enable and power-good on the next edge from any state and returns to the idle state. In the idle state, a sleep request that arrives together with a wake request wins.
- R9: A wake request that arrives during a sequence in progress, or once the domain is fully on, has no effect on the enables or on power-good.
- R10: In mode 2, if `rail_ok` stays low for T cycles after a group closes, `rail_err` rises on the T-th edge. T is `rail_timeout`, and 0 acts as 1. After that no further group closes and `rail_ok` is ignored until a sleep request, which also clears `rail_err`.
- R11: The policy is fixed at the edge that samples the wake request. A later change of `mode_sel` or `wake_urgent` does not alter the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_req | input | 1 | Request to power the domain up |
| wake_urgent | input | 1 | Urgency flag used by the adaptive mode |
| sleep_req | input | 1 | Request to power the domain down |
| mode_sel | input | 2 | 0 fast, 1 timed chain, 2 rail feedback, 3 adaptive |
| step_delay | input | DLY_W | Cycles between consecutive enables in the timed chain |
| rail_ok | input | 1 | Virtual-rail good comparator |
| rail_timeout | input | TMO_W | Watchdog limit in cycles for each feedback step |
| sw_en | output | NUM_GROUPS | Switch group enables, 1 = conducting |
| pwr_good | output | 1 | Domain fully powered |
| rail_err | output | 1 | Feedback step timed out, sequence halted |

## Verification
The in-RTL properties check, on every cycle, the invariants that hold in all sequences. The enables always form a contiguous run from group 0, and outside fast mode at most one group closes per cycle. Power-good implies that all groups are on and rises only after they are. A sleep request clears the outputs on the next edge, and a raised error freezes the enables. The exact spacing of the enables for each delay setting, the latency of each policy, the adaptive choice, and the point at which the watchdog fires can only be shown by the bench. It does this by counting edges from the sampled wake request and comparing each cycle's enable pattern with the pattern expected from the requirements. The bench also shows that a wake request or a mode change in the middle of a sequence leaves that sequence unchanged.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_STEP      = 3'd1,
        ST_WAIT_DLY  = 3'd2,
        ST_WAIT_RAIL = 3'd3,
        ST_ON        = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_FAST  = 2'd0,
        MD_TIMED = 2'd1,
        MD_RAIL  = 2'd2,
        MD_ADAPT = 2'd3
    } wake_mode_e;

endpackage

// File: rtl/pss_timer.sv
module pss_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (load_val == '0) ? ONE : load_val;
        end else if (run && cnt_q > ONE) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && (cnt_q <= ONE);

    // R4 / R10: a loaded window is never empty
    p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (cnt_q != '0));

endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
    import pss_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wake_req,
    input  logic         wake_urgent,
    input  logic         sleep_req,
    input  logic [1:0]   mode_sel,
    input  logic         rail_ok,
    input  logic         dly_exp,
    input  logic         wd_exp,
    output logic         dly_load,
    output logic         dly_run,
    output logic         wd_load,
    output logic         wd_run,
    output logic [N-1:0] sw_en,
    output logic         pwr_good,
    output logic         rail_err
);
    localparam int IDX_W = $clog2(N);
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(N - 1);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
    localparam logic [N-1:0]     EN_ONE  = {{(N-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_state_e       state;
        wake_mode_e       mode;
        logic [IDX_W-1:0] idx;
        logic [N-1:0]     en;
        logic             good;
        logic             err;
    } seq_t;

    seq_t cur_q, nx_d;

    always_comb begin
        nx_d     = cur_q;
        dly_load = 1'b0;
        wd_load  = 1'b0;
        case (cur_q.state)
            ST_OFF: begin
                if (wake_req) begin
                    nx_d.state = ST_STEP;
                    nx_d.idx   = '0;
                    if (wake_mode_e'(mode_sel) == MD_ADAPT)
                        nx_d.mode = wake_urgent ? MD_FAST : MD_TIMED;
                    else
                        nx_d.mode = wake_mode_e'(mode_sel);
                end
            end
            ST_STEP: begin
                if (cur_q.mode == MD_FAST) begin
                    nx_d.en    = '1;
                    nx_d.state = ST_ON;
                end else begin
                    nx_d.en[cur_q.idx] = 1'b1;
                    if (cur_q.mode == MD_TIMED) begin
                        if (cur_q.idx == LAST) begin
                            nx_d.state = ST_ON;
                        end else begin
                            nx_d.state = ST_WAIT_DLY;
                            dly_load   = 1'b1;
                        end
                    end else begin
                        nx_d.state = ST_WAIT_RAIL;
                        wd_load    = 1'b1;
                    end
                end
            end
            ST_WAIT_DLY: begin
                if (dly_exp) begin
                    nx_d.idx          = cur_q.idx + IDX_ONE;
                    nx_d.en[nx_d.idx] = 1'b1;
                    if (nx_d.idx == LAST) nx_d.state = ST_ON;
                    else                  dly_load   = 1'b1;
                end
            end
            ST_WAIT_RAIL: begin
                if (!cur_q.err) begin
                    if (rail_ok) begin
                        if (cur_q.idx == LAST) begin
                            nx_d.state = ST_ON;
                        end else begin
                            nx_d.idx   = cur_q.idx + IDX_ONE;
                            nx_d.state = ST_STEP;
                        end
                    end else if (wd_exp) begin
                        nx_d.err = 1'b1;
                    end
                end
            end
            ST_ON: begin
                nx_d.good = 1'b1;
            end
            default: nx_d.state = ST_OFF;
        endcase
        if (sleep_req) begin
            nx_d.state = ST_OFF;
            nx_d.idx   = '0;
            nx_d.en    = '0;
            nx_d.good  = 1'b0;
            nx_d.err   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state <= ST_OFF;
            cur_q.mode  <= MD_FAST;
            cur_q.idx   <= '0;
            cur_q.en    <= '0;
            cur_q.good  <= 1'b0;
            cur_q.err   <= 1'b0;
        end else begin
            cur_q <= nx_d;
        end
    end

    assign dly_run  = (cur_q.state == ST_WAIT_DLY);
    assign wd_run   = (cur_q.state == ST_WAIT_RAIL) && !cur_q.err;
    assign sw_en    = cur_q.en;
    assign pwr_good = cur_q.good;
    assign rail_err = cur_q.err;

    // R1: reset leaves every output idle
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (sw_en == '0 && !pwr_good && !rail_err));

    // R2: enables are always a contiguous run starting at group 0
    p_thermo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_en & (sw_en + EN_ONE)) == '0));

    // R4 / R5: stepping policies close at most one group per cycle
    p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode != MD_FAST) |-> ($countones(sw_en & ~$past(sw_en)) <= 1));

    // R3: fast step closes the whole bank on the next edge
    p_fast_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_STEP && cur_q.mode == MD_FAST && !sleep_req) |=> (&sw_en));

    // R6: power-good only with every group on, and only after they were on
    p_good_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> (&sw_en));
    p_good_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_good) |-> $past(&sw_en));

    // R8: sleep clears enables and power-good on the next edge
    p_sleep_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> (sw_en == '0 && !pwr_good));

    // R10: a raised error freezes the enables until sleep
    p_err_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_err && !sleep_req) |=> ($stable(sw_en) && rail_err));

endmodule

// File: rtl/pwr_switch_seq.sv
module pwr_switch_seq #(
    parameter int NUM_GROUPS = 8,
    parameter int DLY_W      = 12,
    parameter int TMO_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wake_req,
    input  logic                  wake_urgent,
    input  logic                  sleep_req,
    input  logic [1:0]            mode_sel,
    input  logic [DLY_W-1:0]      step_delay,
    input  logic                  rail_ok,
    input  logic [TMO_W-1:0]      rail_timeout,
    output logic [NUM_GROUPS-1:0] sw_en,
    output logic                  pwr_good,
    output logic                  rail_err
);
    logic dly_load, dly_run, dly_exp;
    logic wd_load, wd_run, wd_exp;

    pss_fsm #(.N(NUM_GROUPS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_req    (wake_req),
        .wake_urgent (wake_urgent),
        .sleep_req   (sleep_req),
        .mode_sel    (mode_sel),
        .rail_ok     (rail_ok),
        .dly_exp     (dly_exp),
        .wd_exp      (wd_exp),
        .dly_load    (dly_load),
        .dly_run     (dly_run),
        .wd_load     (wd_load),
        .wd_run      (wd_run),
        .sw_en       (sw_en),
        .pwr_good    (pwr_good),
        .rail_err    (rail_err)
    );

    pss_timer #(.W(DLY_W)) u_step_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .run      (dly_run),
        .load_val (step_delay),
        .expire   (dly_exp)
    );

    pss_timer #(.W(TMO_W)) u_rail_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wd_load),
        .run      (wd_run),
        .load_val (rail_timeout),
        .expire   (wd_exp)
    );

endmodule

// File: tb/sim_pwr_switch_seq.sv
`timescale 1ns/1ps
module sim_pwr_switch_seq;
    localparam int N     = 8;
    localparam int DLY_W = 12;
    localparam int TMO_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake_req = 1'b0, wake_urgent = 1'b0, sleep_req = 1'b0, rail_ok = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [DLY_W-1:0] step_delay = '0;
    logic [TMO_W-1:0] rail_timeout = '0;
    logic [N-1:0] sw_en;
    logic pwr_good, rail_err;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pwr_switch_seq #(.NUM_GROUPS(N), .DLY_W(DLY_W), .TMO_W(TMO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .wake_urgent(wake_urgent),
        .sleep_req(sleep_req), .mode_sel(mode_sel), .step_delay(step_delay),
        .rail_ok(rail_ok), .rail_timeout(rail_timeout),
        .sw_en(sw_en), .pwr_good(pwr_good), .rail_err(rail_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    typedef struct packed {
        logic [1:0]       mode;
        logic             urg;
        logic [DLY_W-1:0] dly;
        int               lat;
    } vec_t;

    // latency = edges from the wake-sampling edge to power-good: fast 2, timed 2 + (N-1)*D
    localparam vec_t VEC [7] = '{
        '{2'd0, 1'b0, 12'd5,  2},
        '{2'd1, 1'b0, 12'd1,  9},
        '{2'd1, 1'b0, 12'd4,  30},
        '{2'd1, 1'b0, 12'd0,  9},
        '{2'd3, 1'b1, 12'd6,  2},
        '{2'd3, 1'b0, 12'd3,  23},
        '{2'd1, 1'b0, 12'd10, 72}
    };

    function automatic logic [N-1:0] mask(input int k);
        logic [N-1:0] m = '0;
        for (int i = 0; i < N; i++) if (i < k) m[i] = 1'b1;
        return m;
    endfunction

    function automatic int exp_ones(input bit fast, input int d, input int c);
        int eff = (d == 0) ? 1 : d;
        int v;
        if (c < 1) return 0;
        if (fast) return N;
        v = 1 + (c - 1) / eff;
        return (v > N) ? N : v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // wake, then compare every cycle up to power-good; poke_at > 0 injects a
    // mid-sequence wake with a changed mode at that cycle
    task automatic wake_track(input logic [1:0] m, input logic u, input logic [DLY_W-1:0] d,
                              input int lat, input int poke_at, input string req);
        bit fast = (m == 2'd0) || (m == 2'd3 && u);
        bit bad = 0;
        logic [31:0] a_v = 0, e_v = 0;
        @(negedge clk);
        mode_sel = m; wake_urgent = u; step_delay = d; wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        for (int c = 1; c <= lat; c++) begin
            @(negedge clk);
            wake_req = 1'b0;
            if (sw_en !== mask(exp_ones(fast, int'(d), c)) || pwr_good !== (c >= lat)) begin
                if (!bad) begin
                    a_v = {pwr_good, 23'd0, sw_en};
                    e_v = {(c >= lat), 23'd0, mask(exp_ones(fast, int'(d), c))};
                end
                bad = 1;
            end
            if (poke_at > 0 && c == poke_at) begin
                wake_req = 1'b1; mode_sel = 2'd0; wake_urgent = 1'b1;
            end
        end
        chk(!bad, req, "enable pattern and power-good per cycle", a_v, e_v);
    endtask

    task automatic do_sleep(input string req);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        chk(sw_en == '0 && !pwr_good, req, "all off one edge after sleep",
            {pwr_good, sw_en}, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(sw_en == '0 && !pwr_good && !rail_err, "R1", "outputs in reset",
            {rail_err, pwr_good, sw_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sw_en == '0 && !pwr_good && !rail_err, "R1", "outputs after reset",
            {rail_err, pwr_good, sw_en}, 0);

        // table: R3 fast, R4 timed, R7 adaptive, with R2/R6 ordering and power-good timing
        for (int v = 0; v < 7; v++) begin
            wake_track(VEC[v].mode, VEC[v].urg, VEC[v].dly, VEC[v].lat, 0,
                       (VEC[v].mode == 2'd0) ? "R3 R2 R6" :
                       (VEC[v].mode == 2'd1) ? "R4 R2 R6" : "R7 R2 R6");
            do_sleep("R8");
        end

        // R9 R11: mid-sequence wake with mode switched to fast is ignored
        wake_track(2'd1, 1'b0, 12'd3, 23, 4, "R9 R11");
        @(negedge clk); wake_req = 1'b1; mode_sel = 2'd0;
        @(negedge clk); wake_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(sw_en == '1 && pwr_good, "R9", "wake while on has no effect",
            {pwr_good, sw_en}, {1'b1, {N{1'b1}}});
        do_sleep("R8");

        // R5: rail-feedback stepping
        rail_timeout = 16'd100;
        @(negedge clk); mode_sel = 2'd2; wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        @(negedge clk);
        chk(sw_en == mask(1), "R5", "group 0 after wake", sw_en, mask(1));
        for (int k = 0; k < N; k++) begin
            repeat (3) @(negedge clk);
            chk(sw_en == mask(k + 1) && !pwr_good, "R5", "holds while rail low",
                sw_en, mask(k + 1));
            rail_ok = 1'b1;
            @(negedge clk); rail_ok = 1'b0;
            @(negedge clk);
            if (k < N - 1)
                chk(sw_en == mask(k + 2), "R5", "next group after rail good", sw_en, mask(k + 2));
            else
                chk(sw_en == '1 && pwr_good, "R5", "power-good after last rail good",
                    {pwr_good, sw_en}, {1'b1, {N{1'b1}}});
        end
        do_sleep("R8");

        // R10: watchdog on a rail that never rises
        rail_timeout = 16'd6;
        @(negedge clk); mode_sel = 2'd2; wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        @(negedge clk);
        repeat (5) @(negedge clk);
        chk(!rail_err, "R10", "no error before timeout", rail_err, 0);
        @(negedge clk);
        chk(rail_err && sw_en == mask(1), "R10", "error on timeout edge",
            {rail_err, sw_en}, {1'b1, mask(1)});
        rail_ok = 1'b1;
        @(negedge clk); rail_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk(sw_en == mask(1) && rail_err && !pwr_good, "R10", "halted after error",
            {rail_err, sw_en}, {1'b1, mask(1)});
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        chk(!rail_err && sw_en == '0, "R10", "sleep clears error", {rail_err, sw_en}, 0);

        // R8: sleep in the middle of a timed chain
        @(negedge clk); mode_sel = 2'd1; step_delay = 12'd10; wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        repeat (12) @(negedge clk);
        chk(sw_en == mask(2), "R4", "two groups after 11 edges", sw_en, mask(2));
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        chk(sw_en == '0, "R8", "mid-sequence sleep clears", sw_en, 0);
        repeat (25) @(negedge clk);
        chk(sw_en == '0 && !pwr_good, "R8", "stays off after sleep", {pwr_good, sw_en}, 0);

        // R8: sleep beats wake when both arrive in the idle state
        @(negedge clk); mode_sel = 2'd0; wake_req = 1'b1; sleep_req = 1'b1;
        @(negedge clk); wake_req = 1'b0; sleep_req = 1'b0;
        repeat (4) @(negedge clk);
        chk(sw_en == '0 && !pwr_good, "R8", "sleep wins over wake", {pwr_good, sw_en}, 0);

        // R1: reset from the fully-on state
        wake_track(2'd0, 1'b0, 12'd1, 2, 0, "R3");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(sw_en == '0 && !pwr_good && !rail_err, "R1", "reset from on",
            {rail_err, pwr_good, sw_en}, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule